// File: doc/BRIEF.md
# Isolated Gate Driver Control Core

This block is the synchronous decision logic that sits on the output side of a single-channel isolated gate driver. It accepts a non-inverting and an inverting command input and cleans each of them of short glitches. It then decides, each clock cycle, whether the external power switch gate is pulled up by the source stage, pulled down by the sink stage, or clamped. The analog comparators, the level shifter and the isolation barrier sit outside this block. Their verdicts arrive as synchronous single-bit flags: gate supply above its turn-on level, gate supply below its turn-off level, overtemperature trip, temperature cooled below the release point, gate voltage below the clamp threshold, a heartbeat pulse from the input side, and a standby request.

Any protection condition overrides the command inputs and applies one safe pattern. In that pattern the source stage floats, the sink stage conducts and the Miller clamp conducts. When every protection condition has cleared, the outputs again follow the present filtered inputs.

Top module: `gate_drive_ctrl`

## Requirements
- R1: Outside the safe state, `src_drive` is 2'b01 (drive high) with `sink_en`=0 only when the filtered `in_pos`=1 and the filtered `in_neg`=0. For the other three input pairs, `src_drive` is 2'b00 (off) and `sink_en`=1. The output register follows the filter output by one clock.
- R2: A level on `in_pos` or `in_neg` is taken only after it has been held for GLITCH_CYC consecutive clock samples, so a shorter pulse has no effect on the outputs. With the default GLITCH_CYC=3, an input change shows at the outputs after the fourth rising edge.
- R3: In the safe state, `src_drive`=2'b10 (high impedance), `sink_en`=1 and `clamp_en`=1, whatever the command inputs are.
- R4: The undervoltage latch is set at reset and whenever `vh_below_off`=1. It is cleared only by `vh_above_on`=1 while `vh_below_off`=0, and it holds its value while both flags are 0. While the latch is set, the block is in the safe state. A latch change reaches the outputs two clocks after the flag is sampled.
- R5: When the undervoltage latch clears, the outputs take the present filtered inputs without any new input edge.
- R6: `ot_trip`=1 sets an overtemperature latch that forces the safe state. The latch stays set after `ot_trip` falls and clears only when `ot_cool`=1 while `ot_trip`=0.
- R7: The link is treated as lost from reset until the first `heartbeat` pulse, and again once LINK_TIMEOUT cycles pass with no pulse (default 64). While the link is lost, the block is in the safe state. The next heartbeat pulse restores the link.
- R8: `clamp_en` is 1 outside the safe state only while the source is off (`src_drive`=2'b00) and `gate_low` was 1 in the previous cycle.
- R9: `src_drive`=2'b01 and `sink_en`=1 never occur in the same cycle.
- R10: `stby_req`=1 forces the safe state one clock later. When it is removed, normal operation resumes.
- R11: While `rst_n`=0, the outputs are in the safe pattern of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_pos | input | 1 | Non-inverting command input |
| in_neg | input | 1 | Inverting command input |
| vh_above_on | input | 1 | Gate supply above its turn-on level |
| vh_below_off | input | 1 | Gate supply below its turn-off level |
| ot_trip | input | 1 | Junction temperature reached the shutdown point |
| ot_cool | input | 1 | Temperature below the shutdown point minus hysteresis |
| heartbeat | input | 1 | One-cycle pulse from the input side of the link |
| gate_low | input | 1 | Gate voltage below the clamp threshold |
| stby_req | input | 1 | Standby request, forces the safe state |
| src_drive | output | 2 | Source stage: 00 off, 01 drive high, 10 high impedance |
| sink_en | output | 1 | Sink stage enable |
| clamp_en | output | 1 | Miller clamp enable |

## Verification
A protection latch stuck in the wrong state shows at the ports either as a safe pattern that never releases or as a gate that is still driven after a fault. Either one is visible two clocks after the flag changes. A deglitch counter with the wrong length moves the output edge by whole cycles, so the bench samples one cycle before and one cycle after the expected edge. A watchdog limit that is off shows as the safe pattern appearing early or not at all within the timeout window. A wrong interlock or clamp term changes the output in the very next cycle after the input combination is applied.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_HIGH = 2'b01,
        SRC_HIZ  = 2'b10
    } src_state_t;

    typedef struct packed {
        src_state_t src;
        logic       sink;
        logic       clamp;
    } drv_out_t;

    localparam drv_out_t SAFE_PATTERN = '{src: SRC_HIZ, sink: 1'b1, clamp: 1'b1};
endpackage

// File: rtl/gdc_deglitch.sv
module gdc_deglitch #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } dg_t;

    dg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(GLITCH_CYC - 1)) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/gdc_link_watchdog.sv
module gdc_link_watchdog #(
    parameter int LINK_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic heartbeat,
    output logic link_lost
);
    localparam int CW = $clog2(LINK_TIMEOUT + 1);

    typedef struct packed {
        logic          lost;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (heartbeat) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.cnt == CW'(LINK_TIMEOUT - 1)) begin
            st_d.lost = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lost: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign link_lost = st_q.lost;
endmodule

// File: rtl/gdc_protect.sv
module gdc_protect (
    input  logic clk,
    input  logic rst_n,
    input  logic vh_above_on,
    input  logic vh_below_off,
    input  logic ot_trip,
    input  logic ot_cool,
    output logic uv_lat,
    output logic ot_lat
);
    typedef struct packed {
        logic uv;
        logic ot;
    } pr_t;

    pr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vh_below_off)     st_d.uv = 1'b1;
        else if (vh_above_on) st_d.uv = 1'b0;
        if (ot_trip)          st_d.ot = 1'b1;
        else if (ot_cool)     st_d.ot = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{uv: 1'b1, ot: 1'b0};
        else        st_q <= st_d;
    end

    assign uv_lat = st_q.uv;
    assign ot_lat = st_q.ot;
endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl
    import gdc_pkg::*;
#(
    parameter int GLITCH_CYC   = 3,
    parameter int LINK_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_pos,
    input  logic       in_neg,
    input  logic       vh_above_on,
    input  logic       vh_below_off,
    input  logic       ot_trip,
    input  logic       ot_cool,
    input  logic       heartbeat,
    input  logic       gate_low,
    input  logic       stby_req,
    output logic [1:0] src_drive,
    output logic       sink_en,
    output logic       clamp_en
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] filt_in;
    logic              uv_lat;
    logic              ot_lat;
    logic              link_lost;
    logic              safe;
    logic              cmd_on;

    drv_out_t out_d, out_q;

    assign raw_in = {in_neg, in_pos};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_dg
        gdc_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_in[g]),
            .filt (filt_in[g])
        );
    end

    gdc_protect u_prot (
        .clk         (clk),
        .rst_n       (rst_n),
        .vh_above_on (vh_above_on),
        .vh_below_off(vh_below_off),
        .ot_trip     (ot_trip),
        .ot_cool     (ot_cool),
        .uv_lat      (uv_lat),
        .ot_lat      (ot_lat)
    );

    gdc_link_watchdog #(.LINK_TIMEOUT(LINK_TIMEOUT)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .heartbeat(heartbeat),
        .link_lost(link_lost)
    );

    assign safe   = uv_lat | ot_lat | link_lost | stby_req;
    assign cmd_on = filt_in[0] & ~filt_in[1];

    always_comb begin
        if (safe) begin
            out_d = SAFE_PATTERN;
        end else if (cmd_on) begin
            out_d = '{src: SRC_HIGH, sink: 1'b0, clamp: 1'b0};
        end else begin
            out_d = '{src: SRC_OFF, sink: 1'b1, clamp: gate_low};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= SAFE_PATTERN;
        else        out_q <= out_d;
    end

    assign src_drive = out_q.src;
    assign sink_en   = out_q.sink;
    assign clamp_en  = out_q.clamp;
endmodule

// File: rtl/gdc_checker.sv
module gdc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_drive,
    input logic       sink_en,
    input logic       clamp_en,
    input logic       gate_low,
    input logic       stby_req,
    input logic       ot_trip,
    input logic       uv_lat,
    input logic       ot_lat,
    input logic       link_lost
);
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_drive == 2'b01 && sink_en));

    a_r3_safe_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lat || ot_lat || link_lost || stby_req) |=>
            (src_drive == 2'b10 && sink_en && clamp_en));

    a_r8_clamp_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_en && src_drive == 2'b00) |-> $past(gate_low));

    a_r8_clamp_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> src_drive != 2'b01);

    a_r6_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> ot_lat);

    a_r10_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stby_req) |=> src_drive == 2'b10);
endmodule

bind gate_drive_ctrl gdc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_drive(src_drive),
    .sink_en  (sink_en),
    .clamp_en (clamp_en),
    .gate_low (gate_low),
    .stby_req (stby_req),
    .ot_trip  (ot_trip),
    .uv_lat   (uv_lat),
    .ot_lat   (ot_lat),
    .link_lost(link_lost)
);

// File: tb/sim_gate_drive_ctrl.sv
`timescale 1ns/1ps
module sim_gate_drive_ctrl;
    localparam int GLITCH = 3;
    localparam int TOUT   = 64;
    localparam int HB_PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_pos = 0, in_neg = 0, vh_above_on = 0, vh_below_off = 0;
    logic ot_trip = 0, ot_cool = 0, heartbeat = 0, gate_low = 0, stby_req = 0;
    logic hb_en = 0;
    logic [1:0] src_drive;
    logic sink_en, clamp_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gate_drive_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
        .vh_above_on(vh_above_on), .vh_below_off(vh_below_off),
        .ot_trip(ot_trip), .ot_cool(ot_cool), .heartbeat(heartbeat),
        .gate_low(gate_low), .stby_req(stby_req),
        .src_drive(src_drive), .sink_en(sink_en), .clamp_en(clamp_en)
    );

    initial begin : hb_gen
        int k = 0;
        forever begin
            @(negedge clk);
            k = (k + 1) % HB_PER;
            heartbeat = hb_en && (k == 0);
        end
    end

    task automatic chk(string req, logic [1:0] es, logic ek, logic ec);
        checks++;
        if (src_drive !== es || sink_en !== ek || clamp_en !== ec) begin
            fails++;
            $display("FAIL %s: got src=%b sink=%b clamp=%b, expected src=%b sink=%b clamp=%b",
                     req, src_drive, sink_en, clamp_en, es, ek, ec);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_n(2);
        chk("R11 reset", 2'b10, 1, 1);
        rst_n = 1;
        wait_n(3);
        chk("R4 uv latched from reset", 2'b10, 1, 1);
    endtask

    task automatic t_bringup();
        vh_above_on = 1;
        wait_n(3);
        chk("R7 link lost before first heartbeat", 2'b10, 1, 1);
        hb_en = 1;
        wait_n(HB_PER + 4);
        chk("R1 idle off after bring-up", 2'b00, 1, 0);
    endtask

    task automatic t_truth();
        in_pos = 1; in_neg = 0; wait_n(GLITCH + 2);
        chk("R1 pos=1 neg=0", 2'b01, 0, 0);
        in_pos = 1; in_neg = 1; wait_n(GLITCH + 2);
        chk("R1 pos=1 neg=1 interlock", 2'b00, 1, 0);
        in_pos = 0; in_neg = 1; wait_n(GLITCH + 2);
        chk("R1 pos=0 neg=1", 2'b00, 1, 0);
        gate_low = 1; wait_n(2);
        chk("R8 clamp with gate low while off", 2'b00, 1, 1);
        in_pos = 1; in_neg = 0; wait_n(GLITCH + 2);
        chk("R8 no clamp while driving", 2'b01, 0, 0);
        in_pos = 0; in_neg = 0; wait_n(GLITCH + 2);
        chk("R8 clamp again when off", 2'b00, 1, 1);
        gate_low = 0; wait_n(2);
        chk("R8 clamp released gate high", 2'b00, 1, 0);
    endtask

    task automatic t_glitch();
        in_pos = 1;
        wait_n(GLITCH - 1);
        in_pos = 0;
        for (int i = 0; i < GLITCH + 2; i++) begin
            @(negedge clk);
            chk("R2 short pulse ignored", 2'b00, 1, 0);
        end
        in_pos = 1;
        wait_n(GLITCH);
        chk("R2 not yet taken", 2'b00, 1, 0);
        wait_n(1);
        chk("R2 taken after hold", 2'b01, 0, 0);
        in_neg = 1;
        wait_n(GLITCH - 1);
        in_neg = 0;
        wait_n(GLITCH + 2);
        chk("R2 short neg pulse ignored", 2'b01, 0, 0);
    endtask

    task automatic t_uv();
        vh_above_on = 0; vh_below_off = 1;
        wait_n(1);
        chk("R4 latency one", 2'b01, 0, 0);
        wait_n(1);
        chk("R3 uv safe", 2'b10, 1, 1);
        vh_below_off = 0;
        wait_n(6);
        chk("R4 hysteresis hold", 2'b10, 1, 1);
        in_pos = 0; wait_n(GLITCH + 2);
        in_pos = 1; wait_n(GLITCH + 2);
        chk("R3 inputs ignored in safe", 2'b10, 1, 1);
        vh_above_on = 1;
        wait_n(2);
        chk("R5 follows present inputs", 2'b01, 0, 0);
    endtask

    task automatic t_ot();
        ot_trip = 1; wait_n(1); ot_trip = 0;
        wait_n(1);
        chk("R6 trip safe", 2'b10, 1, 1);
        wait_n(10);
        chk("R6 latched after trip falls", 2'b10, 1, 1);
        ot_cool = 1; wait_n(2); ot_cool = 0;
        chk("R6 released by cool flag", 2'b01, 0, 0);
    endtask

    task automatic t_link();
        @(posedge heartbeat);
        @(negedge clk);
        hb_en = 0;
        wait_n(TOUT - 8);
        chk("R7 before timeout", 2'b01, 0, 0);
        wait_n(16);
        chk("R7 timeout safe", 2'b10, 1, 1);
        hb_en = 1;
        wait_n(HB_PER + 3);
        chk("R7 restored", 2'b01, 0, 0);
    endtask

    task automatic t_stby();
        stby_req = 1; wait_n(1);
        chk("R10 standby safe", 2'b10, 1, 1);
        stby_req = 0; wait_n(1);
        chk("R10 standby exit", 2'b01, 0, 0);
        in_pos = 0; wait_n(GLITCH + 2);
        chk("R9 off after standby", 2'b00, 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog: run hung, got timeout, expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_bringup();
        t_truth();
        t_glitch();
        t_uv();
        t_ot();
        t_link();
        t_stby();
        finish_run();
    end
endmodule